// File: doc/BRIEF.md
# Integer Arithmetic Execute Unit

This unit executes one 32-bit integer instruction per cycle. It decodes the primary opcode and the function code. For immediate forms it widens the 16-bit constant by sign or zero extension, as each instruction requires. It then produces one of the following results:

- a sum or difference
- a bitwise AND or OR
- a signed or unsigned less-than flag
- a logical shift by a 5-bit amount

Shifts go through a barrel shifter that is separate from the adder. The unit also raises an overflow exception flag for the instructions that trap on signed overflow.

A second path widens a loaded byte into a full word. The caller chooses sign extension or zero extension. All outputs are registered, so results appear one clock after the inputs are presented. The register file, memory, branches and the exception handler sit outside this unit. Operand `opa` carries the first source register and `opb` carries the second source register.

Top module: `int_exec_unit`

## Requirements
- R1: The trapping forms raise `ovf_exc` when the two's-complement result overflows. These are add (opcode 0x00, funct 0x20), sub (opcode 0x00, funct 0x22) and addi (opcode 0x08). For add and sub, overflow is operands of equal sign (after negating the subtrahend) giving a sum of the other sign. `result` still holds the wrapped 32-bit value.
- R2: The non-trapping forms never raise `ovf_exc` and return the wrapped value. These are addu (funct 0x21), subu (funct 0x23) and addiu (opcode 0x09).
- R3: The 16-bit immediate in bits 15..0 is sign-extended for addi, addiu, slti (0x0A) and sltiu (0x0B). It is zero-extended for andi (0x0C) and ori (0x0D).
- R4: slt (funct 0x2A) and slti compare `opa` against the second operand as signed values. The result is 1 when `opa` is smaller and 0 otherwise.
- R5: sltu (funct 0x2B) and sltiu compare as unsigned values. The result is 1 exactly when `opa` minus the operand borrows.
- R6: sll (funct 0x00) and srl (funct 0x02) shift `opb` by the shamt field in bits 10..6. The shift amount ranges from 0 to 31, and zeros fill the vacated bits.
- R7: and (funct 0x24), or (funct 0x25), andi and ori return the bitwise AND or OR.
- R8: When `byte_load` is high, `ld_word` one cycle later holds `byte_val` in bits 7..0. Bits 31..8 are copies of bit 7 when `byte_signed` is high, and zeros when it is low. `ld_word` is 0 when `byte_load` is low.
- R9: An unknown opcode, or an unknown funct under opcode 0x00, sets `illegal` with `result` equal to 0 and `ovf_exc` low.
- R10: `out_valid` follows `in_valid` by one cycle. While `out_valid` is low, `result`, `ovf_exc` and `illegal` are 0.
- R11: Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| opa | input | 32 | First source register value |
| opb | input | 32 | Second source register value |
| byte_load | input | 1 | Byte widening request |
| byte_signed | input | 1 | 1 = sign-extend, 0 = zero-extend |
| byte_val | input | 8 | Loaded byte |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Instruction result |
| ovf_exc | output | 1 | Overflow exception |
| illegal | output | 1 | Unrecognised instruction |
| ld_word | output | 32 | Widened byte |

## Verification
The bench probes both overflow boundaries: the largest positive value plus one, and the most negative value minus one. It drives each of these through the trapping and the non-trapping forms. A unit that ignored the trap distinction, or tested overflow on the carry out, would flag the wrong one.

Immediates of 0xFFFF and 0x8000 expose an extension mix-up. andi would then return all ones, and sltiu would compare against a small number instead of 0xFFFFFFFF.

An all-ones operand compared against zero separates signed from unsigned compares.

Shifts by 0 and by 31 catch off-by-one errors in the shifter stages. Illegal encodings carry operands that would overflow, to show that no flag leaks through.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  typedef enum logic [2:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_SLT, K_SLTU, K_SLL, K_SRL
  } kind_t;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;
endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
  import iexu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output kind_t      kind,
  output logic       use_imm,
  output logic       imm_sign,
  output logic       trap_en,
  output logic       bad
);
  always_comb begin
    kind     = K_ADD;
    use_imm  = 1'b0;
    imm_sign = 1'b0;
    trap_en  = 1'b0;
    bad      = 1'b0;
    unique case (opcode)
      OPC_REG: begin
        unique case (funct)
          FN_SLL:  kind = K_SLL;
          FN_SRL:  kind = K_SRL;
          FN_ADD:  begin kind = K_ADD; trap_en = 1'b1; end
          FN_ADDU: kind = K_ADD;
          FN_SUB:  begin kind = K_SUB; trap_en = 1'b1; end
          FN_SUBU: kind = K_SUB;
          FN_AND:  kind = K_AND;
          FN_OR:   kind = K_OR;
          FN_SLT:  kind = K_SLT;
          FN_SLTU: kind = K_SLTU;
          default: bad = 1'b1;
        endcase
      end
      OPC_ADDI:  begin kind = K_ADD;  use_imm = 1'b1; imm_sign = 1'b1; trap_en = 1'b1; end
      OPC_ADDIU: begin kind = K_ADD;  use_imm = 1'b1; imm_sign = 1'b1; end
      OPC_SLTI:  begin kind = K_SLT;  use_imm = 1'b1; imm_sign = 1'b1; end
      OPC_SLTIU: begin kind = K_SLTU; use_imm = 1'b1; imm_sign = 1'b1; end
      OPC_ANDI:  begin kind = K_AND;  use_imm = 1'b1; end
      OPC_ORI:   begin kind = K_OR;   use_imm = 1'b1; end
      default:   bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
  import iexu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  kind_t             kind,
  output logic [DATA_W-1:0] y,
  output logic              sovf
);
  localparam int MSB = DATA_W - 1;

  logic              do_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] sum;
  logic              carry;
  logic              lt_s;
  logic              lt_u;

  // Compares reuse the subtract path.
  assign do_sub = (kind == K_SUB) || (kind == K_SLT) || (kind == K_SLTU);
  assign b_eff  = do_sub ? ~b : b;
  assign wide   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
  assign sum    = wide[DATA_W-1:0];
  assign carry  = wide[DATA_W];

  // Same-sign inputs to the adder producing a flipped sign bit.
  assign sovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  assign lt_s = sum[MSB] ^ sovf;
  assign lt_u = ~carry;

  always_comb begin
    unique case (kind)
      K_ADD, K_SUB: y = sum;
      K_AND:        y = a & b;
      K_OR:         y = a | b;
      K_SLT:        y = {{(DATA_W-1){1'b0}}, lt_s};
      K_SLTU:       y = {{(DATA_W-1){1'b0}}, lt_u};
      default:      y = '0;
    endcase
  end
endmodule

// File: rtl/iexu_shift.sv
module iexu_shift #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              right,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  // One fixed power-of-two stage per amount bit: equal delay for any amount.
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int DIST = 1 << k;
    logic [DATA_W-1:0] moved;
    assign moved = right ? (stage[k] >> DIST) : (stage[k] << DIST);
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign dout = stage[SH_W];
endmodule

// File: rtl/iexu_byte_ext.sv
module iexu_byte_ext #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] bval,
  input  logic              sgn,
  output logic [DATA_W-1:0] word
);
  localparam int PAD_W = DATA_W - BYTE_W;

  logic fill;
  assign fill = sgn & bval[BYTE_W-1];
  assign word = {{PAD_W{fill}}, bval};
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IMM_W   = 16,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic               byte_load,
  input  logic               byte_signed,
  input  logic [BYTE_W-1:0]  byte_val,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result,
  output logic               ovf_exc,
  output logic               illegal,
  output logic [DATA_W-1:0]  ld_word
);
  localparam int SH_W  = $clog2(DATA_W);
  localparam int SH_LO = 6;
  localparam int EXT_W = DATA_W - IMM_W;

  kind_t             kind;
  logic              use_imm, imm_sign, trap_en, bad;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] imm_ext, b_sel, alu_y, sh_y, ext_w, nxt_res;
  logic              sovf, is_shift;

  iexu_decode u_dec (
    .opcode   (instr[INSTR_W-1 -: 6]),
    .funct    (instr[5:0]),
    .kind     (kind),
    .use_imm  (use_imm),
    .imm_sign (imm_sign),
    .trap_en  (trap_en),
    .bad      (bad)
  );

  assign imm     = instr[IMM_W-1:0];
  assign imm_ext = {{EXT_W{imm_sign & imm[IMM_W-1]}}, imm};
  assign b_sel   = use_imm ? imm_ext : opb;

  iexu_alu #(.DATA_W(DATA_W)) u_alu (
    .a    (opa),
    .b    (b_sel),
    .kind (kind),
    .y    (alu_y),
    .sovf (sovf)
  );

  iexu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) u_sh (
    .din   (opb),
    .amt   (instr[SH_LO +: SH_W]),
    .right (kind == K_SRL),
    .dout  (sh_y)
  );

  iexu_byte_ext #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bx (
    .bval (byte_val),
    .sgn  (byte_signed),
    .word (ext_w)
  );

  assign is_shift = (kind == K_SLL) || (kind == K_SRL);
  assign nxt_res  = bad ? '0 : (is_shift ? sh_y : alu_y);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf_exc   <= 1'b0;
      illegal   <= 1'b0;
      ld_word   <= '0;
    end else begin
      out_valid <= in_valid;
      result    <= in_valid ? nxt_res : '0;
      ovf_exc   <= in_valid & ~bad & trap_en & sovf;
      illegal   <= in_valid & bad;
      ld_word   <= byte_load ? ext_w : '0;
    end
  end
endmodule

// File: rtl/iexu_checker.sv
module iexu_checker #(
  parameter int DATA_W  = 32,
  parameter int INSTR_W = 32,
  parameter int BYTE_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               byte_load,
  input logic               byte_signed,
  input logic               out_valid,
  input logic [DATA_W-1:0]  result,
  input logic               ovf_exc,
  input logic               illegal,
  input logic [DATA_W-1:0]  ld_word
);
  localparam int PAD_W = DATA_W - BYTE_W;

  logic [5:0] opc, fn;
  logic       trap_kind, cmp_kind;
  assign opc       = instr[INSTR_W-1 -: 6];
  assign fn        = instr[5:0];
  assign trap_kind = (opc == 6'h08) || (opc == 6'h00 && (fn == 6'h20 || fn == 6'h22));
  assign cmp_kind  = (opc == 6'h0A) || (opc == 6'h0B) ||
                     (opc == 6'h00 && (fn == 6'h2A || fn == 6'h2B));

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (result == '0 && !ovf_exc && !illegal));
  assert_trap_only_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !trap_kind) |=> !ovf_exc);
  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (result == '0 && !ovf_exc));
  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_exc, illegal}));
  assert_cmp_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cmp_kind) |=> (result[DATA_W-1:1] == '0));
  assert_sext_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_load && byte_signed) |=> (ld_word[DATA_W-1:BYTE_W] == {PAD_W{ld_word[BYTE_W-1]}}));
  assert_zext_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_load && !byte_signed) |=> (ld_word[DATA_W-1:BYTE_W] == '0));
endmodule

bind int_exec_unit iexu_checker #(.DATA_W(DATA_W), .INSTR_W(INSTR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .instr       (instr),
  .byte_load   (byte_load),
  .byte_signed (byte_signed),
  .out_valid   (out_valid),
  .result      (result),
  .ovf_exc     (ovf_exc),
  .illegal     (illegal),
  .ld_word     (ld_word)
);

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        byte_load = 1'b0;
  logic        byte_signed = 1'b0;
  logic [7:0]  byte_val = '0;
  logic        out_valid, ovf_exc, illegal;
  logic [31:0] result, ld_word;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .opa(opa), .opb(opb),
    .byte_load(byte_load), .byte_signed(byte_signed), .byte_val(byte_val),
    .out_valid(out_valid), .result(result), .ovf_exc(ovf_exc), .illegal(illegal),
    .ld_word(ld_word)
  );

  function automatic logic [31:0] rt_i(input logic [5:0] fn, input logic [4:0] sa);
    return {6'h00, 5'd1, 5'd2, 5'd3, sa, fn};
  endfunction

  function automatic logic [31:0] im_i(input logic [5:0] op, input logic [15:0] k);
    return {op, 5'd1, 5'd2, k};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Present one instruction, sample the registered outputs one cycle later.
  task automatic run(input string tag, input logic [31:0] ins, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] exp_res,
                     input logic exp_ovf, input logic exp_ill);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " result"}, result, exp_res);
    chk({tag, " ovf"}, {31'd0, ovf_exc}, {31'd0, exp_ovf});
    chk({tag, " illegal"}, {31'd0, illegal}, {31'd0, exp_ill});
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R11 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R11 reset result", result, 32'd0);
    chk("R11 reset ld_word", ld_word, 32'd0);
  endtask

  task automatic t_trap();
    run("R1 add +max+1", rt_i(6'h20, 0), 32'h7FFFFFFF, 32'h1, 32'h80000000, 1'b1, 1'b0);
    run("R1 add no ovf", rt_i(6'h20, 0), 32'hFFFFFFFF, 32'h5, 32'h4, 1'b0, 1'b0);
    run("R1 sub min-1", rt_i(6'h22, 0), 32'h80000000, 32'h1, 32'h7FFFFFFF, 1'b1, 1'b0);
    run("R1 add neg+neg", rt_i(6'h20, 0), 32'h80000000, 32'h80000000, 32'h0, 1'b1, 1'b0);
    run("R1 addi ovf", im_i(6'h08, 16'h0001), 32'h7FFFFFFF, 32'h0, 32'h80000000, 1'b1, 1'b0);
  endtask

  task automatic t_notrap();
    run("R2 addu wrap", rt_i(6'h21, 0), 32'h7FFFFFFF, 32'h1, 32'h80000000, 1'b0, 1'b0);
    run("R2 subu wrap", rt_i(6'h23, 0), 32'h80000000, 32'h1, 32'h7FFFFFFF, 1'b0, 1'b0);
    run("R2 addiu wrap", im_i(6'h09, 16'h0001), 32'h7FFFFFFF, 32'h0, 32'h80000000, 1'b0, 1'b0);
  endtask

  task automatic t_imm();
    run("R3 addi -1", im_i(6'h08, 16'hFFFF), 32'd5, 32'h0, 32'd4, 1'b0, 1'b0);
    run("R3 addiu sext", im_i(6'h09, 16'h8000), 32'h0, 32'h0, 32'hFFFF8000, 1'b0, 1'b0);
    run("R3 andi zext", im_i(6'h0C, 16'hFFFF), 32'hFFFFFFFF, 32'h0, 32'h0000FFFF, 1'b0, 1'b0);
    run("R3 ori zext", im_i(6'h0D, 16'h8000), 32'h0, 32'hFFFFFFFF, 32'h00008000, 1'b0, 1'b0);
  endtask

  task automatic t_cmp();
    run("R4 slt -1<0", rt_i(6'h2A, 0), 32'hFFFFFFFF, 32'h0, 32'd1, 1'b0, 1'b0);
    run("R4 slt max<min", rt_i(6'h2A, 0), 32'h7FFFFFFF, 32'h80000000, 32'd0, 1'b0, 1'b0);
    run("R4 slt equal", rt_i(6'h2A, 0), 32'd9, 32'd9, 32'd0, 1'b0, 1'b0);
    run("R4 slti -2<-1", im_i(6'h0A, 16'hFFFF), 32'hFFFFFFFE, 32'h0, 32'd1, 1'b0, 1'b0);
    run("R5 sltu ones<0", rt_i(6'h2B, 0), 32'hFFFFFFFF, 32'h0, 32'd0, 1'b0, 1'b0);
    run("R5 sltu 0<ones", rt_i(6'h2B, 0), 32'h0, 32'hFFFFFFFF, 32'd1, 1'b0, 1'b0);
    run("R5 sltiu 5<big", im_i(6'h0B, 16'hFFFF), 32'd5, 32'h0, 32'd1, 1'b0, 1'b0);
  endtask

  task automatic t_shift();
    run("R6 sll 4", rt_i(6'h00, 5'd4), 32'h0, 32'hFEEDBEEF, 32'hEEDBEEF0, 1'b0, 1'b0);
    run("R6 srl 12", rt_i(6'h02, 5'd12), 32'h0, 32'hFEEDBEEF, 32'h000FEEDB, 1'b0, 1'b0);
    run("R6 sll 0", rt_i(6'h00, 5'd0), 32'hFFFFFFFF, 32'h12345678, 32'h12345678, 1'b0, 1'b0);
    run("R6 sll 31", rt_i(6'h00, 5'd31), 32'h0, 32'h00000003, 32'h80000000, 1'b0, 1'b0);
    run("R6 srl 31", rt_i(6'h02, 5'd31), 32'h0, 32'h80000001, 32'h00000001, 1'b0, 1'b0);
  endtask

  task automatic t_logic();
    run("R7 and", rt_i(6'h24, 0), 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0);
    run("R7 or", rt_i(6'h25, 0), 32'hF0F0F0F0, 32'h0F000F00, 32'hFFF0FFF0, 1'b0, 1'b0);
  endtask

  task automatic t_byte();
    @(negedge clk);
    byte_load = 1'b1; byte_signed = 1'b1; byte_val = 8'h9C;
    @(negedge clk);
    chk("R8 signed byte", ld_word, 32'hFFFFFF9C);
    byte_signed = 1'b0;
    @(negedge clk);
    chk("R8 unsigned byte", ld_word, 32'h0000009C);
    byte_signed = 1'b1; byte_val = 8'h7F;
    @(negedge clk);
    chk("R8 signed positive", ld_word, 32'h0000007F);
    byte_load = 1'b0;
    @(negedge clk);
    chk("R8 no load", ld_word, 32'h0);
  endtask

  task automatic t_illegal();
    run("R9 bad opcode", im_i(6'h3F, 16'h0001), 32'h7FFFFFFF, 32'h1, 32'h0, 1'b0, 1'b1);
    run("R9 bad funct", rt_i(6'h01, 0), 32'h7FFFFFFF, 32'h1, 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    instr = rt_i(6'h21, 0); opa = 32'h11; opb = 32'h22;
    @(negedge clk);
    chk("R10 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R10 idle result", result, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_trap();
    t_notrap();
    t_imm();
    t_cmp();
    t_shift();
    t_logic();
    t_byte();
    t_illegal();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule